// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns one character into one asynchronous serial frame each time it is asked to. A start strobe, taken while the block is idle, captures a data byte, an extra-bit value and the frame-format fields. The block then drives the serial line through a low start bit, 5 to 8 data bits sent LSB first, an optional parity bit, an optional extra bit and a stop period. Every bit time is counted in baud ticks, which arrive at 16 times the bit rate from a divider outside the block. The line idles high.

The format is chosen at run time. The data length is 5 to 8 bits. Parity can be odd, even, forced high (mark) or forced low (space). An extra bit can be appended. The stop period can be short or long. Format and data are latched when the frame starts, so the driving logic may change them during a frame without corrupting it. A busy flag covers the whole frame. A one-cycle done pulse marks the end of the stop period. After reset the latched format is 8 data bits, no parity, no extra bit and a short stop.

The controller is a state machine with six states. IDLE goes to START on an accepted strobe. START goes to DATA after one bit time. DATA stays in DATA until the last data bit has been sent, then goes to PARITY if parity is on, to EXTRA if only the extra bit is on, and to STOP otherwise. PARITY goes to EXTRA or STOP. EXTRA goes to STOP. STOP returns to IDLE when its period ends, which also raises done.

Top module: `uart_frame_tx`

## Requirements
- R1: While idle (after reset and between frames) `txd` is 1, `busy` is 0 and `done` is 0.
- R2: A frame begins with a start bit of level 0, followed by the data bits LSB first. The start bit and every data, parity and extra bit last exactly 16 baud ticks.
- R3: `fmt_len` selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Byte bits above the selected length are not sent.
- R4: When `fmt_par_en` is 1, a parity bit is sent right after the last data bit. When it is 0, no parity bit is sent.
- R5: `fmt_par_kind` sets the parity bit. 2'b00 is odd: the count of ones over the sent data bits plus the parity bit is odd. 2'b01 is even: that count is even. 2'b10 is mark: the bit is always 1. 2'b11 is space: the bit is always 0.
- R6: When `fmt_xb_en` is 1, the value of `xbit` is sent as one more bit after the data bits. If parity is also on, the extra bit comes after the parity bit.
- R7: The stop level (1) lasts 16 ticks when `fmt_stop_long` is 0. When `fmt_stop_long` is 1 it lasts 32 ticks for 6, 7 or 8 data bits and 24 ticks for 5 data bits.
- R8: A start strobe seen while idle makes `busy` 1 from the next cycle until the frame ends. A strobe seen while busy is ignored: the frame in progress is unchanged and no further frame follows it.
- R9: `done` is 1 for exactly one clock cycle, in the cycle in which `busy` first reads 0 after the stop period.
- R10: Data, extra bit and format fields are sampled only when a frame is accepted. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send one frame; taken only while idle |
| tx_data | input | 8 | Character to send |
| xbit | input | 1 | Value of the appended extra bit |
| fmt_len | input | 2 | Data length select |
| fmt_par_en | input | 1 | Parity bit enable |
| fmt_par_kind | input | 2 | Parity kind: odd, even, mark, space |
| fmt_xb_en | input | 1 | Extra bit enable |
| fmt_stop_long | input | 1 | Long stop period select |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions check on every cycle that the line is high whenever the block is idle and that a frame opens with a low level. They also check that the line changes only after a baud tick once a frame is under way, that an accepted strobe raises busy, and that done is a single-cycle pulse tied to the fall of busy. The assertions cannot see bit order, data length, the parity value, where the extra bit falls or how long the stop period lasts. Only the bench's directed frames can show those, by recording the line at every tick and comparing the record with a frame the bench builds itself. The same holds for ignored strobes and mid-frame format changes, which the bench applies partway through a frame.

// File: rtl/uart_txf_pkg.sv
`timescale 1ns/1ps
package uart_txf_pkg;
    localparam int DATA_W = 8;
    localparam int LEN_W  = 2;
    localparam int NB_W   = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_EXTRA,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             par_en;
        par_kind_e        par_kind;
        logic             xb_en;
        logic             stop_long;
    } frame_fmt_t;
endpackage

// File: rtl/uart_txf_format.sv
`timescale 1ns/1ps
module uart_txf_format
    import uart_txf_pkg::*;
#(
    parameter int TICKS = 16,
    parameter int CW    = 6
) (
    input  logic [LEN_W-1:0]  len,
    input  par_kind_e         par_kind,
    input  logic              stop_long,
    input  logic [DATA_W-1:0] data,
    output logic [NB_W-1:0]   n_bits,
    output logic              par_bit,
    output logic [CW-1:0]     stop_ticks
);
    localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;

    logic [DATA_W-1:0] masked;

    assign n_bits = NB_W'(MIN_BITS) + NB_W'(len);

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] & (NB_W'(i) < n_bits);
    end

    always_comb begin
        unique case (par_kind)
            PAR_ODD:   par_bit = ~(^masked);
            PAR_EVEN:  par_bit = ^masked;
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default:   par_bit = 1'b0;
        endcase
    end

    always_comb begin
        if (!stop_long)
            stop_ticks = CW'(TICKS);
        else if (n_bits == NB_W'(MIN_BITS))
            stop_ticks = CW'(TICKS + TICKS / 2);
        else
            stop_ticks = CW'(2 * TICKS);
    end
endmodule

// File: rtl/uart_txf_tickcnt.sv
`timescale 1ns/1ps
module uart_txf_tickcnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          bit_end
);
    logic [CW-1:0] cnt;

    assign bit_end = tick && !clear && (cnt == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear || bit_end)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/uart_txf_ctrl.sv
`timescale 1ns/1ps
module uart_txf_ctrl
    import uart_txf_pkg::*;
#(
    parameter int TICKS = 16,
    parameter int CW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    input  logic              xbit_in,
    input  frame_fmt_t        fmt_in,
    input  logic              bit_end,
    input  logic [NB_W-1:0]   n_bits,
    input  logic              par_bit,
    input  logic [CW-1:0]     stop_ticks,
    output frame_fmt_t        fmt_q,
    output logic [DATA_W-1:0] data_q,
    output logic [CW-1:0]     limit,
    output logic              cnt_clear,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W = $clog2(DATA_W);

    tx_state_e         state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic              xbit_q;
    logic              last_data;

    assign last_data = ({1'b0, bit_idx} == n_bits - NB_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_START;
            ST_START:  if (bit_end) nxt = ST_DATA;
            ST_DATA:
                if (bit_end && last_data) begin
                    if (fmt_q.par_en)     nxt = ST_PARITY;
                    else if (fmt_q.xb_en) nxt = ST_EXTRA;
                    else                  nxt = ST_STOP;
                end
            ST_PARITY: if (bit_end) nxt = fmt_q.xb_en ? ST_EXTRA : ST_STOP;
            ST_EXTRA:  if (bit_end) nxt = ST_STOP;
            ST_STOP:   if (bit_end) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // frame datapath: capture at accept, shift per data bit, end pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q   <= '{len: 2'b11, par_en: 1'b0, par_kind: PAR_ODD,
                         xb_en: 1'b0, stop_long: 1'b0};
            data_q  <= '0;
            shreg   <= '0;
            xbit_q  <= 1'b0;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= (state == ST_STOP) && bit_end;
            if (state == ST_IDLE && start) begin
                fmt_q   <= fmt_in;
                data_q  <= data_in;
                shreg   <= data_in;
                xbit_q  <= xbit_in;
                bit_idx <= '0;
            end else if (state == ST_DATA && bit_end) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_bit;
            ST_EXTRA:  txd = xbit_q;
            ST_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
        busy      = (state != ST_IDLE);
        cnt_clear = (state == ST_IDLE);
        limit     = (state == ST_STOP) ? stop_ticks : CW'(TICKS);
    end
endmodule

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
    import uart_txf_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  tx_data,
    input  logic        xbit,
    input  logic [1:0]  fmt_len,
    input  logic        fmt_par_en,
    input  logic [1:0]  fmt_par_kind,
    input  logic        fmt_xb_en,
    input  logic        fmt_stop_long,
    input  logic        baud_tick,
    output logic        txd,
    output logic        busy,
    output logic        done
);
    localparam int CW = $clog2(2 * TICKS + 1);

    frame_fmt_t        fmt_in, fmt_q;
    logic [DATA_W-1:0] data_q;
    logic [NB_W-1:0]   n_bits;
    logic              par_bit;
    logic [CW-1:0]     stop_ticks, limit;
    logic              bit_end, cnt_clear;

    assign fmt_in = '{len: fmt_len, par_en: fmt_par_en,
                      par_kind: par_kind_e'(fmt_par_kind),
                      xb_en: fmt_xb_en, stop_long: fmt_stop_long};

    uart_txf_ctrl #(.TICKS(TICKS), .CW(CW)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .data_in(tx_data),
        .xbit_in(xbit), .fmt_in(fmt_in), .bit_end(bit_end),
        .n_bits(n_bits), .par_bit(par_bit), .stop_ticks(stop_ticks),
        .fmt_q(fmt_q), .data_q(data_q), .limit(limit),
        .cnt_clear(cnt_clear), .txd(txd), .busy(busy), .done(done)
    );

    uart_txf_format #(.TICKS(TICKS), .CW(CW)) i_fmt (
        .len(fmt_q.len), .par_kind(fmt_q.par_kind),
        .stop_long(fmt_q.stop_long), .data(data_q),
        .n_bits(n_bits), .par_bit(par_bit), .stop_ticks(stop_ticks)
    );

    uart_txf_tickcnt #(.CW(CW)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .tick(baud_tick),
        .limit(limit), .bit_end(bit_end)
    );
endmodule

// File: rtl/uart_frame_tx_chk.sv
`timescale 1ns/1ps
module uart_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] tx_data,
    input logic       xbit,
    input logic [1:0] fmt_len,
    input logic       fmt_par_en,
    input logic [1:0] fmt_par_kind,
    input logic       fmt_xb_en,
    input logic       fmt_stop_long,
    input logic       baud_tick,
    input logic       txd,
    input logic       busy,
    input logic       done
);
    logic unused_ok;
    assign unused_ok = ^{tx_data, xbit, fmt_len, fmt_par_en, fmt_par_kind,
                         fmt_xb_en, fmt_stop_long};

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    p_line_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(baud_tick)) |-> $stable(txd));

    p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

bind uart_frame_tx uart_frame_tx_chk i_chk (.*);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       xbit = 1'b0;
    logic [1:0] fmt_len = 2'b11;
    logic       fmt_par_en = 1'b0;
    logic [1:0] fmt_par_kind = 2'b00;
    logic       fmt_xb_en = 1'b0;
    logic       fmt_stop_long = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, busy, done;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    uart_frame_tx i_uart_frame_tx (.*);

    always #2 clk = ~clk;

    // baud tick: one cycle in four, changed just after the rising edge
    initial begin
        int tdiv = 0;
        forever begin
            @(posedge clk);
            #1;
            tdiv = (tdiv + 1) % 4;
            baud_tick = (tdiv == 0);
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        finish_run();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    endtask

    // kind 0: plain frame; kind 1: strobe with other data while busy;
    // kind 2: change format inputs while busy
    task automatic run_frame(input string req, input logic [7:0] d, input logic xb,
                             input logic [1:0] len, input logic pe, input logic [1:0] pk,
                             input logic xe, input logic sl, input int kind);
        logic [255:0] exp_s;
        logic [255:0] got_s;
        int en, gn, mism, first_bad, guard, nb, ones, sticks;
        logic pbit;
        bit rel;
        en = 0; gn = 0; mism = 0; first_bad = -1; guard = 0; rel = 1'b0;
        exp_s = '0; got_s = '0;
        nb = 5 + int'(len);
        ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        case (pk)
            2'b00: pbit = (ones % 2 == 0);
            2'b01: pbit = (ones % 2 == 1);
            2'b10: pbit = 1'b1;
            default: pbit = 1'b0;
        endcase
        sticks = !sl ? 16 : (nb == 5 ? 24 : 32);
        for (int k = 0; k < 16; k++) exp_s[en++] = 1'b0;
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < 16; k++) exp_s[en++] = d[i];
        if (pe) for (int k = 0; k < 16; k++) exp_s[en++] = pbit;
        if (xe) for (int k = 0; k < 16; k++) exp_s[en++] = xb;
        for (int k = 0; k < sticks; k++) exp_s[en++] = 1'b1;

        @(negedge clk);
        tx_data = d; xbit = xb; fmt_len = len; fmt_par_en = pe;
        fmt_par_kind = pk; fmt_xb_en = xe; fmt_stop_long = sl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", {req, " busy after strobe"}, int'(busy), 1);
        chk(txd == 1'b0, "R2", {req, " start bit level"}, int'(txd), 0);
        forever begin
            if (done || guard > 4000) break;
            if (rel) begin start = 1'b0; rel = 1'b0; end
            if (baud_tick) begin
                if (gn < 256) got_s[gn] = txd;
                gn++;
            end
            if (gn == 40 && kind == 1 && !rel) begin
                start = 1'b1; rel = 1'b1; kind = 0;
                tx_data = ~d; xbit = ~xb;
            end
            if (gn == 40 && kind == 2) begin
                kind = 0;
                fmt_len = ~len; fmt_par_en = ~pe; fmt_par_kind = ~pk;
                fmt_xb_en = ~xe; fmt_stop_long = ~sl; tx_data = ~d;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        for (int i = 0; i < en; i++)
            if (got_s[i] !== exp_s[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        chk(gn == en, req, "frame length in ticks", gn, en);
        chk(mism == 0, req, "line level at first differing tick", first_bad, -1);
        chk(busy == 1'b0, "R9", {req, " busy low with done"}, int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", {req, " done lasts one cycle"}, int'(done), 0);
        chk(txd == 1'b1 && busy == 1'b0, "R1", {req, " idle after frame"},
            int'({txd, busy}), 2);
        repeat (8) @(negedge clk);
        chk(busy == 1'b0, "R8", {req, " no second frame"}, int'(busy), 0);
    endtask

    task automatic test_basic();      run_frame("R2/R3 8-bit no parity", 8'hA5, 1'b0, 2'b11, 1'b0, 2'b00, 1'b0, 1'b0, 0); endtask
    task automatic test_short_len();  run_frame("R3 5-bit upper bits dropped", 8'hFF, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 0); endtask
    task automatic test_odd6();       run_frame("R4/R5 6-bit odd", 8'h2B, 1'b0, 2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 0); endtask
    task automatic test_even5();      run_frame("R5/R7 5-bit even long stop", 8'hE3, 1'b0, 2'b00, 1'b1, 2'b01, 1'b0, 1'b1, 0); endtask
    task automatic test_mark7();      run_frame("R5 7-bit mark", 8'h00, 1'b0, 2'b10, 1'b1, 2'b10, 1'b0, 1'b0, 0); endtask
    task automatic test_space8();     run_frame("R5 8-bit space", 8'hFF, 1'b0, 2'b11, 1'b1, 2'b11, 1'b0, 1'b0, 0); endtask
    task automatic test_extra();      run_frame("R6 extra bit only", 8'h3C, 1'b1, 2'b11, 1'b0, 2'b00, 1'b1, 1'b0, 0); endtask
    task automatic test_par_extra();  run_frame("R6 parity then extra", 8'h81, 1'b0, 2'b11, 1'b1, 2'b00, 1'b1, 1'b0, 0); endtask
    task automatic test_long8();      run_frame("R7 8-bit long stop", 8'h5A, 1'b0, 2'b11, 1'b0, 2'b00, 1'b0, 1'b1, 0); endtask
    task automatic test_busy_strobe(); run_frame("R8 strobe while busy", 8'h96, 1'b1, 2'b11, 1'b1, 2'b01, 1'b1, 1'b0, 1); endtask
    task automatic test_cfg_change(); run_frame("R10 format change mid-frame", 8'h4D, 1'b0, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, 2); endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_basic();
        test_short_len();
        test_odd6();
        test_even5();
        test_mark7();
        test_space8();
        test_extra();
        test_par_extra();
        test_long8();
        test_busy_strobe();
        test_cfg_change();
        finish_run();
    end
endmodule